// File: doc/BRIEF.md
# Segment Break Comparator

This block keeps two 8-bit limit values. One applies to the privileged segments, the other to every remaining segment. On each memory reference it takes a 7-bit segment number and a 16-bit logical offset. It picks a limit by decoding the segment number and compares the high byte of the offset against that limit. The resulting flag goes to the memory-management logic, which can use it to keep a region such as a stack apart from the rest of the segment.

Software reaches both limit values through a small port-style interface. A single select bit picks the limit, a write strobe loads it, and a combinational read path returns it. The decode depends only on the segment number, so the CPU's execution mode has no effect on which limit is used. The flag settles in the same cycle as the reference strobe.

Top module: `segbrk_top`

## Requirements
- R1: After a synchronous reset, both limit values read back as 0x00.
- R2: When `io_wr` is high at a clock edge, `io_wdata` is loaded into the system limit if `io_sel`=0, or into the user limit if `io_sel`=1. The other limit keeps its value.
- R3: `io_rdata` shows the system limit when `io_sel`=0 and the user limit when `io_sel`=1. The read is combinational.
- R4: Segment numbers 0, 1, 64 and 65 use the system limit. Every other value from 0 to 127 uses the user limit. `ref_sys` is high exactly when the system limit is in use.
- R5: While `ref_valid` is high, `above_break` is 1 when `ref_offset[15:8]` is greater than or equal to the selected limit, and 0 otherwise. The result appears in the same cycle.
- R6: While `ref_valid` is low, `above_break` is 0.
- R7: Changing `ref_offset[7:0]` has no effect on `above_break`.
- R8: A limit written at an edge is used for comparisons from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 1 | Limit select: 0 = system, 1 = user |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the selected limit |
| ref_valid | input | 1 | Memory reference strobe |
| ref_seg | input | 7 | Segment number |
| ref_offset | input | 16 | Logical offset |
| ref_sys | output | 1 | Reference uses the system limit |
| above_break | output | 1 | Offset high byte is at or above the limit |

## Verification
The assertions check on every cycle that:
- the flag is low when no reference is present;
- `ref_sys` agrees with the four privileged segment numbers;
- a write reaches the register picked by the select bit and leaves the other one unchanged.

Several properties can only be shown by the bench's scenarios:
- the read-after-reset values;
- the exact comparison boundary, where the high byte equals the limit;
- the independence from the low offset byte;
- next-cycle use of a freshly written limit across random segments.

// File: rtl/segbrk_pkg.sv
package segbrk_pkg;
    localparam int SEG_W  = 7;
    localparam int OFF_W  = 16;
    localparam int LIM_W  = 8;

    typedef enum logic {LIM_SYS = 1'b0, LIM_USR = 1'b1} lim_sel_e;

    typedef struct packed {
        logic [LIM_W-1:0] sys_lim;
        logic [LIM_W-1:0] usr_lim;
    } lim_pair_t;

    function automatic logic seg_is_sys(input logic [SEG_W-1:0] seg);
        return (seg[SEG_W-2:1] == '0);
    endfunction
endpackage

// File: rtl/segbrk_regs.sv
module segbrk_regs
    import segbrk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  lim_sel_e         sel,
    input  logic             wr,
    input  logic [LIM_W-1:0] wdata,
    output logic [LIM_W-1:0] rdata,
    output lim_pair_t        lims
);
    lim_pair_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr) begin
            if (sel == LIM_SYS) q.sys_lim <= wdata;
            else                q.usr_lim <= wdata;
        end
    end

    assign lims  = q;
    assign rdata = (sel == LIM_SYS) ? q.sys_lim : q.usr_lim;

    a_r2_wr_sys: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == LIM_SYS) |=> (q.sys_lim == $past(wdata) && $stable(q.usr_lim)));
    a_r2_wr_usr: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == LIM_USR) |=> (q.usr_lim == $past(wdata) && $stable(q.sys_lim)));
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(q));
endmodule

// File: rtl/segbrk_cmp.sv
module segbrk_cmp
    import segbrk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] offset,
    input  lim_pair_t        lims,
    output logic             is_sys,
    output logic             above
);
    logic [LIM_W-1:0] lim;
    logic [LIM_W-1:0] hi;

    always_comb begin
        is_sys = seg_is_sys(seg);
        lim    = is_sys ? lims.sys_lim : lims.usr_lim;
        hi     = offset[OFF_W-1:OFF_W-LIM_W];
        above  = valid && (hi >= lim);
    end

    a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
        !valid |-> !above);
    a_r4_sys_set: assert property (@(posedge clk) disable iff (rst)
        is_sys |-> (seg == 7'd0 || seg == 7'd1 || seg == 7'd64 || seg == 7'd65));
    a_r4_usr_set: assert property (@(posedge clk) disable iff (rst)
        (seg == 7'd0 || seg == 7'd1 || seg == 7'd64 || seg == 7'd65) |-> is_sys);
endmodule

// File: rtl/segbrk_top.sv
module segbrk_top
    import segbrk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        io_sel,
    input  logic        io_wr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic        ref_valid,
    input  logic [6:0]  ref_seg,
    input  logic [15:0] ref_offset,
    output logic        ref_sys,
    output logic        above_break
);
    lim_pair_t lims;
    lim_sel_e  sel;

    assign sel = lim_sel_e'(io_sel);

    segbrk_regs u_regs (
        .clk(clk), .rst(rst), .sel(sel), .wr(io_wr),
        .wdata(io_wdata), .rdata(io_rdata), .lims(lims)
    );

    segbrk_cmp u_cmp (
        .clk(clk), .rst(rst), .valid(ref_valid), .seg(ref_seg),
        .offset(ref_offset), .lims(lims), .is_sys(ref_sys), .above(above_break)
    );
endmodule

// File: tb/sim_segbrk_top.sv
module sim_segbrk_top;
    logic clk = 0;
    logic rst = 1;
    logic io_sel = 0, io_wr = 0;
    logic [7:0] io_wdata = 0;
    logic [7:0] io_rdata;
    logic ref_valid = 0;
    logic [6:0] ref_seg = 0;
    logic [15:0] ref_offset = 0;
    logic ref_sys, above_break;

    int n_chk = 0, n_fail = 0;
    logic [7:0] m_sys = 0, m_usr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    segbrk_top u0 (.*);

    function automatic bit exp_sys(input logic [6:0] s);
        return (s == 0 || s == 1 || s == 64 || s == 65);
    endfunction

    function automatic bit exp_above(input bit v, input logic [6:0] s, input logic [15:0] o,
                                     input logic [7:0] ls, input logic [7:0] lu);
        logic [7:0] l;
        l = exp_sys(s) ? ls : lu;
        return v && (o[15:8] >= l);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_lim(input bit s, input logic [7:0] d);
        io_sel = s; io_wr = 1; io_wdata = d;
        @(posedge clk); #1;
        io_wr = 0;
        if (s) m_usr = d; else m_sys = d;
    endtask

    task automatic probe(input bit v, input logic [6:0] s, input logic [15:0] o, input string req);
        ref_valid = v; ref_seg = s; ref_offset = o;
        #2;
        check(req, {15'd0, above_break}, {15'd0, exp_above(v, s, o, m_sys, m_usr)});
        check("R4", {15'd0, ref_sys}, {15'd0, exp_sys(s)});
        #1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(posedge clk);
        #1 rst = 0;
        // R1 reset values
        io_sel = 0; #1 check("R1", {8'd0, io_rdata}, 16'h0000);
        io_sel = 1; #1 check("R1", {8'd0, io_rdata}, 16'h0000);
        // R2/R3/R8 writes
        wr_lim(0, 8'h40);
        io_sel = 0; #1 check("R3", {8'd0, io_rdata}, 16'h0040);
        io_sel = 1; #1 check("R2", {8'd0, io_rdata}, 16'h0000);
        wr_lim(1, 8'h80);
        io_sel = 0; #1 check("R2", {8'd0, io_rdata}, 16'h0040);
        io_sel = 1; #1 check("R3", {8'd0, io_rdata}, 16'h0080);
        // R4/R5 boundaries, R8 next-cycle use
        probe(1, 7'd0,  16'h3FFF, "R5");
        probe(1, 7'd1,  16'h4000, "R5");
        probe(1, 7'd64, 16'h4000, "R4");
        probe(1, 7'd65, 16'h3F00, "R4");
        probe(1, 7'd2,  16'h7FFF, "R5");
        probe(1, 7'd66, 16'h8000, "R5");
        probe(1, 7'd127,16'h4000, "R4");
        probe(1, 7'd63, 16'hFFFF, "R8");
        // R6 no valid
        probe(0, 7'd0,  16'hFFFF, "R6");
        probe(0, 7'd10, 16'hFFFF, "R6");
        // R7 low byte ignored
        probe(1, 7'd5, 16'h7F00, "R7");
        probe(1, 7'd5, 16'h7FFF, "R7");
        probe(1, 7'd0, 16'h3F00, "R7");
        probe(1, 7'd0, 16'h3FFF, "R7");
        // R8: update then compare next cycle
        wr_lim(0, 8'h3F);
        probe(1, 7'd0, 16'h3F00, "R8");
        wr_lim(1, 8'hFF);
        probe(1, 7'd9, 16'hFE00, "R8");
        probe(1, 7'd9, 16'hFF00, "R8");
        // random
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 4) == 0) wr_lim($urandom % 2, 8'($urandom));
            probe(($urandom % 8) != 0, 7'($urandom), 16'($urandom), "R5");
            @(posedge clk); #1;
        end
        io_sel = 0; #1 check("R3", {8'd0, io_rdata}, {8'd0, m_sys});
        io_sel = 1; #1 check("R3", {8'd0, io_rdata}, {8'd0, m_usr});
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule